// File: doc/BRIEF.md
# Shared Lock Register for Multiple Bus Masters

This block is a single 32-bit lock word that several bus masters share, so that they can agree on which of them uses a common resource, such as a message RAM. The upper half of the word holds the identifier of the current holder. The lower half holds a lock value, and any nonzero value means the lock is taken. A master claims the lock with one write that carries its own fixed identifier and a nonzero value. That single write both tests and sets the lock, so no other master can get in between the two steps. The master then reads the word back and compares the holder field with its own identifier to learn whether the claim succeeded. To let go of the lock, it writes its identifier with a zero value.

The block only advises. It gates nothing on the protected resource, and software must take the lock before it touches that resource. Each master has its own write strobe and write word. When several masters write in the same cycle, a fixed-priority selector applies only the write of the lowest-numbered master. All masters see the same read word, which always shows the registered state.

Top module: `mutex_lock_top`

## Requirements
- R1: While reset is held, and after it is released, the read word is owner 0 and value 0 (with default parameters), which means the lock is free.
- R2: The lock is free when the value field [15:0] is 0. A write with a nonzero value to a free lock stores the written owner [31:16] and value.
- R3: A write with a nonzero value whose owner field equals the stored owner, while the lock is held, replaces the stored value.
- R4: A write with a nonzero value from a different owner, while the lock is held, is ignored. The word keeps its old contents.
- R5: A write with value 0 whose owner field equals the stored owner clears the value to 0 and keeps the owner field.
- R6: A write with value 0 whose owner field differs from the stored owner is ignored.
- R7: When several masters write in the same cycle, only the write of the lowest-numbered master is judged and applied. This holds even if that write is then rejected. The writes of all other masters in that cycle have no effect.
- R8: The read word shows the result of a write from the first clock edge after the write is presented. Without a write, the read word stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | NUM_MASTERS | Write strobe for each master |
| wr_data | input | NUM_MASTERS*32 | Write word for each master; master i uses bits [32*i+31:32*i] |
| rd_data | output | 32 | Current lock word: owner [31:16], value [15:0] |
| locked | output | 1 | High while the stored value is nonzero |

## Verification
Each write updates the lock word at the first rising edge after the write is presented. The bench therefore drives its inputs on the falling edge and compares rd_data and locked on the next falling edge, half a period after the register has updated. A model in the bench applies the priority and ownership rules to predict the word for every cycle. Each comparison is tagged with the rule that decided the outcome: claim, update, rejected claim, release, rejected release, collision, or idle.

// File: rtl/mutex_pkg.sv
package mutex_pkg;
    localparam int OWNER_W = 16;
    localparam int VALUE_W = 16;
    localparam int WORD_W  = OWNER_W + VALUE_W;

    typedef struct packed {
        logic [OWNER_W-1:0] owner;
        logic [VALUE_W-1:0] value;
    } lock_word_t;
endpackage

// File: rtl/mutex_prio_sel.sv
module mutex_prio_sel #(
    parameter int N = 4,
    parameter int W = 32
) (
    input  logic [N-1:0]   req,
    input  logic [N*W-1:0] data,
    output logic [N-1:0]   grant,
    output logic           sel_valid,
    output logic [W-1:0]   sel_data
);
    logic [N:0] pending;

    assign pending[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_chain
            assign grant[gi]     = req[gi] & ~pending[gi];
            assign pending[gi+1] = pending[gi] | req[gi];
        end
    endgenerate

    assign sel_valid = pending[N];

    always_comb begin
        sel_data = '0;
        for (int i = 0; i < N; i++) begin
            sel_data = sel_data | (data[i*W +: W] & {W{grant[i]}});
        end
    end
endmodule

// File: rtl/mutex_lock_core.sv
module mutex_lock_core
    import mutex_pkg::*;
#(
    parameter logic [OWNER_W-1:0] INIT_OWNER = '0,
    parameter logic [VALUE_W-1:0] INIT_VALUE = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_valid,
    input  lock_word_t         sel_word,
    output logic [OWNER_W-1:0] cur_owner,
    output logic [VALUE_W-1:0] cur_value
);
    lock_word_t state_d, state_q;
    logic       held;
    logic       same_owner;

    assign held       = (state_q.value != '0);
    assign same_owner = (sel_word.owner == state_q.owner);

    always_comb begin
        state_d = state_q;
        if (sel_valid) begin
            if (sel_word.value != '0) begin
                if (!held || same_owner) begin
                    state_d = sel_word;
                end
            end else if (same_owner) begin
                state_d.value = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.owner <= INIT_OWNER;
            state_q.value <= INIT_VALUE;
        end else begin
            state_q <= state_d;
        end
    end

    assign cur_owner = state_q.owner;
    assign cur_value = state_q.value;
endmodule

// File: rtl/mutex_lock_top.sv
module mutex_lock_top
    import mutex_pkg::*;
#(
    parameter int                 NUM_MASTERS = 4,
    parameter logic [OWNER_W-1:0] INIT_OWNER  = '0,
    parameter logic [VALUE_W-1:0] INIT_VALUE  = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_MASTERS-1:0]        wr_en,
    input  logic [NUM_MASTERS*WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0]             rd_data,
    output logic                          locked
);
    logic [NUM_MASTERS-1:0] grant;
    logic                   sel_valid;
    logic [WORD_W-1:0]      sel_raw;
    lock_word_t             sel_word;
    logic [OWNER_W-1:0]     cur_owner;
    logic [VALUE_W-1:0]     cur_value;

    mutex_prio_sel #(
        .N (NUM_MASTERS),
        .W (WORD_W)
    ) u_sel (
        .req       (wr_en),
        .data      (wr_data),
        .grant     (grant),
        .sel_valid (sel_valid),
        .sel_data  (sel_raw)
    );

    assign sel_word = lock_word_t'(sel_raw);

    mutex_lock_core #(
        .INIT_OWNER (INIT_OWNER),
        .INIT_VALUE (INIT_VALUE)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_valid (sel_valid),
        .sel_word  (sel_word),
        .cur_owner (cur_owner),
        .cur_value (cur_value)
    );

    assign rd_data = {cur_owner, cur_value};
    assign locked  = (cur_value != '0);
endmodule

// File: rtl/mutex_lock_chk.sv
module mutex_lock_chk
    import mutex_pkg::*;
#(
    parameter int N = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N-1:0]       grant,
    input logic [N-1:0]       req,
    input logic               sel_valid,
    input lock_word_t         sel_word,
    input logic [OWNER_W-1:0] cur_owner,
    input logic [VALUE_W-1:0] cur_value
);
    // R7
    grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~req) == '0));

    // R2
    claim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && sel_word.value != '0 && cur_value == '0) |=>
        (cur_owner == $past(sel_word.owner) && cur_value == $past(sel_word.value)));

    // R4
    foreign_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && sel_word.value != '0 && cur_value != '0 && sel_word.owner != cur_owner) |=>
        ($stable(cur_owner) && $stable(cur_value)));

    // R5
    release_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && sel_word.value == '0 && sel_word.owner == cur_owner) |=>
        (cur_value == '0 && $stable(cur_owner)));

    // R6
    foreign_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && sel_word.value == '0 && sel_word.owner != cur_owner) |=>
        ($stable(cur_owner) && $stable(cur_value)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> ($stable(cur_owner) && $stable(cur_value)));
endmodule

bind mutex_lock_top mutex_lock_chk #(.N(NUM_MASTERS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (grant),
    .req       (wr_en),
    .sel_valid (sel_valid),
    .sel_word  (sel_word),
    .cur_owner (cur_owner),
    .cur_value (cur_value)
);

// File: tb/mutex_lock_top_tb.sv
module mutex_lock_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NM         = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NM-1:0]   wr_en;
    logic [NM*32-1:0] wr_data;
    logic [31:0]     rd_data;
    logic            locked;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] model;

    always #(CLK_PERIOD/2) clk = ~clk;

    mutex_lock_top #(.NUM_MASTERS(NM)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .locked  (locked)
    );

    function automatic logic [31:0] next_word(logic [31:0] cur, logic [NM-1:0] en,
                                              logic [NM*32-1:0] dat);
        logic [31:0] w;
        logic [31:0] r;
        int          win;
        r   = cur;
        win = -1;
        for (int i = NM-1; i >= 0; i--) if (en[i]) win = i;
        if (win >= 0) begin
            w = dat[win*32 +: 32];
            if (w[15:0] != 16'd0) begin
                if (cur[15:0] == 16'd0 || w[31:16] == cur[31:16]) r = w;
            end else if (w[31:16] == cur[31:16]) begin
                r[15:0] = 16'd0;
            end
        end
        return r;
    endfunction

    function automatic string rule_tag(logic [31:0] cur, logic [NM-1:0] en,
                                       logic [NM*32-1:0] dat);
        logic [31:0] w;
        int          win;
        win = -1;
        for (int i = NM-1; i >= 0; i--) if (en[i]) win = i;
        if (win < 0) return "R8";
        if ($countones(en) > 1) return "R7";
        w = dat[win*32 +: 32];
        if (w[15:0] != 16'd0) begin
            if (cur[15:0] == 16'd0) return "R2";
            if (w[31:16] == cur[31:16]) return "R3";
            return "R4";
        end
        if (w[31:16] == cur[31:16]) return "R5";
        return "R6";
    endfunction

    task automatic check(string tag, logic [31:0] exp);
        checks++;
        if (rd_data !== exp || locked !== (exp[15:0] != 16'd0)) begin
            errors++;
            $display("FAIL %s: rd_data=%h locked=%b expected %h locked=%b",
                     tag, rd_data, locked, exp, (exp[15:0] != 16'd0));
        end
    endtask

    task automatic step(logic [NM-1:0] en, logic [NM*32-1:0] dat);
        string tag;
        tag     = rule_tag(model, en, dat);
        wr_en   = en;
        wr_data = dat;
        @(posedge clk);
        model   = next_word(model, en, dat);
        @(negedge clk);
        wr_en   = '0;
        check(tag, model);
    endtask

    function automatic logic [NM*32-1:0] put(int m, logic [15:0] id, logic [15:0] v);
        logic [NM*32-1:0] d;
        d = '0;
        d[m*32 +: 32] = {id, v};
        return d;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [NM-1:0]    en;
        logic [NM*32-1:0] dat;
        void'($urandom(32'd2024));
        rst_n   = 1'b0;
        wr_en   = '0;
        wr_data = '0;
        model   = 32'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 32'd0);

        // directed corner cases
        step(4'b0100, put(2, 16'd3, 16'd1));                 // R2 claim by id 3
        step(4'b0010, put(1, 16'd2, 16'd1));                 // R4 rejected
        step(4'b0100, put(2, 16'd3, 16'd5));                 // R3 update
        step(4'b0001, put(0, 16'd2, 16'd0));                 // R6 foreign release
        step(4'b0100, put(2, 16'd3, 16'd0));                 // R5 release
        step(4'b1010, put(1, 16'd2, 16'd1) | put(3, 16'd4, 16'd1)); // R7 low index wins
        check("R7", {16'd2, 16'd1});
        // winner rejected, release from lower priority must not apply: R7
        step(4'b0011, put(0, 16'd1, 16'd1) | put(1, 16'd2, 16'd0));
        check("R7", {16'd2, 16'd1});
        step(4'b0000, '0);                                   // R8 idle hold
        step(4'b1000, put(3, 16'd2, 16'd0));                 // R5 release via other port
        step(4'b1001, put(0, 16'd7, 16'd9) | put(3, 16'd4, 16'd2)); // R7 on free lock

        // constrained random traffic
        for (int n = 0; n < 400; n++) begin
            en  = NM'($urandom_range(0, (1 << NM) - 1));
            if ($urandom_range(0, 3) == 0) en = '0;
            dat = '0;
            for (int m = 0; m < NM; m++) begin
                logic [15:0] id;
                logic [15:0] v;
                id = 16'($urandom_range(1, 5));
                case ($urandom_range(0, 2))
                    0: v = 16'd0;
                    1: v = 16'd1;
                    default: v = 16'($urandom);
                endcase
                dat[m*32 +: 32] = {id, v};
            end
            step(en, dat);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule